// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an 8-bit general-purpose I/O port that sits on an APB-style slave bus. It keeps one data register and one direction register. Each pin gets an output value and an output enable from these registers, and the port samples each pin's input level. The data register can be reached at any word in the lower 1 KiB of the port's space. The word address of an access, taken from bits [9:2], is used as a per-bit mask. Software can therefore set, clear or read any group of pins in one transfer, with no read-modify-write sequence and no shared-variable race between drivers.

Input levels pass through a two-flop synchroniser before software can read them. The port stays closed to software for a few clocks after its module clock enable rises. Any access in that window still completes, but it reports a slave error and has no effect. Once the port is open, every transfer completes in its access phase with no wait states.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, `pin_oe` and `pin_out` are all zeros, and the data and direction registers both read 0.
- R2: A write to word offset `0x000`–`0x3FC` updates data bit i only when address bit i+2 is 1. Every other data bit keeps its value.
- R3: A read from the data region returns 0 in every bit i whose address bit i+2 is 0.
- R4: For a pin whose direction bit is 1, a masked read of the data region returns the last value written to that bit.
- R5: For a pin whose direction bit is 0, a masked read returns the pin level through two flops. A level applied just before clock edge k can be read after edge k+1 and not earlier.
- R6: `pin_oe` equals the direction register. `pin_out` bit i carries the data bit only while direction bit i is 1, and is 0 otherwise.
- R7: The direction register is at byte offset `0x400`, with 1 meaning output. A write there is read back unchanged.
- R8: Bits 31:8 of every read are 0, and write data in bits 31:8 has no effect on any register.
- R9: An access in an access phase before `clk_en` has been high for three rising clock edges completes with `pslverr` = 1. It reads 0 and changes no register. Lowering `clk_en` restarts the count.
- R10: Once the port is open, `pready` is 1 in every access phase and `pslverr` is 0. An offset at or above `0x404`, or at `0x800`, reads 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and port clock |
| presetn | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Module clock enable; starts the ready count |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte offset within the port |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer complete |
| pslverr | output | 1 | Access made before the port was ready |
| pin_in | input | 8 | Pin input levels |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |

## Verification
A write takes effect on the rising edge that ends its access phase. `pin_out`, `pin_oe` and later reads therefore show the new value from the following falling edge, and the bench samples them there. Read data is combinational from the registers and the second synchroniser stage. Reads are sampled on the falling edge of the access phase, before the completing edge. The synchroniser test holds a read address steady while the pin changes. It then samples `prdata` one and two edges later and expects the old level and then the new one. The ready window is tested by counting rising edges from the rise of `clk_en`: the transfer whose access phase comes before the third edge must report an error.

// File: rtl/gpio_mask_port.sv
module gpio_mask_port #(
  parameter int WIDTH        = 8,
  parameter int AW           = 12,
  parameter int DW           = 32,
  parameter int READY_CYCLES = 3
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          clk_en,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  output logic          pready,
  output logic          pslverr,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);

  localparam int CW = $clog2(READY_CYCLES + 1);
  localparam int WA = AW - 2;
  localparam logic [WA-1:0] DIR_WORD = WA'(1 << WIDTH);

  logic [CW-1:0]    cnt_q;
  logic [WIDTH-1:0] data_q, dir_q, sync1_q, sync2_q;
  logic             rdy;

  wire [WA-1:0]    word    = paddr[AW-1:2];
  wire [WIDTH-1:0] amask   = paddr[WIDTH+1:2];
  wire             hit_dat = (word[WA-1:WIDTH] == '0);
  wire             hit_dir = (word == DIR_WORD);
  wire             access  = psel & penable;
  wire             wr_ok   = access & pwrite & rdy;
  wire             wr_dat  = wr_ok & hit_dat;
  wire             wr_dir  = wr_ok & hit_dir;
  wire [WIDTH-1:0] wbyte   = pwdata[WIDTH-1:0];
  wire [WIDTH-1:0] view    = (data_q & dir_q) | (sync2_q & ~dir_q);
  wire             unused_bits = ^{paddr[1:0], pwdata[DW-1:WIDTH]};

  assign rdy = (cnt_q == CW'(READY_CYCLES));

  always_ff @(posedge pclk or negedge presetn)
    if (!presetn)         cnt_q <= '0;
    else if (!clk_en)     cnt_q <= '0;
    else if (!rdy)        cnt_q <= cnt_q + 1'b1;

  always_ff @(posedge pclk or negedge presetn)
    if (!presetn) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end

  always_ff @(posedge pclk or negedge presetn)
    if (!presetn)    data_q <= '0;
    else if (wr_dat) data_q <= (data_q & ~amask) | (wbyte & amask);

  always_ff @(posedge pclk or negedge presetn)
    if (!presetn)    dir_q <= '0;
    else if (wr_dir) dir_q <= wbyte;

  always_comb begin
    prdata = '0;
    if (psel && !pwrite && rdy) begin
      if (hit_dat)      prdata[WIDTH-1:0] = view & amask;
      else if (hit_dir) prdata[WIDTH-1:0] = dir_q;
    end
  end

  assign pready  = 1'b1;
  assign pslverr = access & ~rdy;
  assign pin_oe  = dir_q;
  assign pin_out = data_q & dir_q;

  assert_keep_unmasked_R2: assert property (@(posedge pclk) disable iff (!presetn)
    wr_dat |=> ((data_q ^ $past(data_q)) & ~$past(amask)) == '0);

  assert_read_mask_R3: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !pwrite && hit_dat) |-> (prdata[WIDTH-1:0] & ~amask) == '0);

  assert_dir_load_R7: assert property (@(posedge pclk) disable iff (!presetn)
    wr_dir |=> pin_oe == $past(wbyte));

  assert_early_noeffect_R9: assert property (@(posedge pclk) disable iff (!presetn)
    (access && !rdy) |=> ($stable(data_q) && $stable(dir_q)));

  assert_restart_R9: assert property (@(posedge pclk) disable iff (!presetn)
    !clk_en |=> !rdy);

endmodule

// File: tb/test_gpio_mask_port.sv
module test_gpio_mask_port;
  logic        pclk = 1'b0, presetn = 1'b0, clk_en = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic        pready, pslverr;
  logic [7:0]  pin_in = '0, pin_out, pin_oe;
  int          n_run = 0, n_fail = 0;
  logic [31:0] rd;
  logic        er;

  gpio_mask_port i_gpio_mask_port (
    .pclk(pclk), .presetn(presetn), .clk_en(clk_en), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  always #10 pclk = ~pclk;

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [11:0] a, input logic [31:0] d,
                      output logic [31:0] r, output logic e);
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = w; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    #1;
    r = prdata; e = pslverr;
    if (e == 1'b0) chk("R10 pready", {31'b0, pready}, 32'd1);
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 pin_oe", {24'b0, pin_oe}, 0);
    chk("R1 pin_out", {24'b0, pin_out}, 0);
  endtask

  task automatic t_ready;
    @(negedge pclk); clk_en = 1'b1;
    xfer(1, 12'h400, 32'hFF, rd, er);
    chk("R9 early error", {31'b0, er}, 1);
    chk("R9 early no effect", {24'b0, pin_oe}, 0);
    xfer(0, 12'h400, 0, rd, er);
    chk("R9 ready no error", {31'b0, er}, 0);
    chk("R1 dir reads 0", rd, 0);
    xfer(0, 12'h3FC, 0, rd, er);
    chk("R1 data reads 0", rd, 0);
  endtask

  task automatic t_dir;
    xfer(1, 12'h400, 32'h0F, rd, er);
    xfer(0, 12'h400, 0, rd, er);
    chk("R7 dir readback", rd, 32'h0F);
    chk("R6 pin_oe", {24'b0, pin_oe}, 32'h0F);
  endtask

  task automatic t_data;
    xfer(1, 12'h400, 32'hFF, rd, er);
    xfer(1, 12'h3FC, 32'hA5, rd, er);
    xfer(0, 12'h3FC, 0, rd, er);
    chk("R4 readback", rd, 32'hA5);
    xfer(1, 12'h00C, 32'h5A, rd, er);
    xfer(0, 12'h3FC, 0, rd, er);
    chk("R2 masked write", rd, 32'hA6);
    xfer(0, 12'h3C0, 0, rd, er);
    chk("R3 high nibble read", rd, 32'hA0);
    xfer(0, 12'h000, 0, rd, er);
    chk("R3 empty mask", rd, 0);
  endtask

  task automatic t_gate;
    xfer(1, 12'h400, 32'h0F, rd, er);
    chk("R6 pin_out gated", {24'b0, pin_out}, 32'h06);
    chk("R6 pin_oe follows", {24'b0, pin_oe}, 32'h0F);
  endtask

  task automatic t_input;
    pin_in = 8'h5C;
    repeat (3) @(negedge pclk);
    xfer(0, 12'h3FC, 0, rd, er);
    chk("R5 mixed read", rd, 32'h56);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; paddr = 12'h3FC; pin_in = 8'h3C;
    #1; chk("R5 no edge yet", prdata, 32'h56);
    @(negedge pclk); #1; chk("R5 one edge", prdata, 32'h56);
    @(negedge pclk); #1; chk("R5 two edges", prdata, 32'h36);
    psel = 1'b0;
  endtask

  task automatic t_upper;
    xfer(1, 12'h400, 32'hFFFF_FF0F, rd, er);
    xfer(0, 12'h400, 0, rd, er);
    chk("R8 dir upper ignored", rd, 32'h0F);
    xfer(1, 12'h3FC, 32'hFFFF_FF00, rd, er);
    xfer(0, 12'h3FC, 0, rd, er);
    chk("R8 data upper zero", rd, 32'h30);
  endtask

  task automatic t_undecoded;
    xfer(1, 12'h800, 32'hFF, rd, er);
    xfer(1, 12'h404, 32'hFF, rd, er);
    chk("R10 no error", {31'b0, er}, 0);
    xfer(0, 12'h400, 0, rd, er);
    chk("R10 dir untouched", rd, 32'h0F);
    chk("R10 pin_out untouched", {24'b0, pin_out}, 0);
    xfer(0, 12'h800, 0, rd, er);
    chk("R10 undecoded read", rd, 0);
    xfer(0, 12'h404, 0, rd, er);
    chk("R10 undecoded read 404", rd, 0);
  endtask

  task automatic t_restart;
    @(negedge pclk); clk_en = 1'b0;
    @(negedge pclk); clk_en = 1'b1;
    xfer(0, 12'h400, 0, rd, er);
    chk("R9 restart error", {31'b0, er}, 1);
    chk("R9 restart read 0", rd, 0);
    xfer(0, 12'h400, 0, rd, er);
    chk("R9 reopened", rd, 32'h0F);
  endtask

  initial begin
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    t_reset();
    t_ready();
    t_dir();
    t_data();
    t_gate();
    t_input();
    t_upper();
    t_undecoded();
    t_restart();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule